// File: doc/BRIEF.md
# Parallel FIFO Handshake Engine

This block sits between an internal host and an external 8-bit asynchronous parallel FIFO device. The device has two active-low status lines, one for data available to read and one for room to accept a write. It has two active-low strobes, one for read and one for write. The host starts a write by pulsing `wr_req` with a byte on `wr_byte`, or starts a read by pulsing `rd_req`. It can then do other work and poll `busy`, `wr_done` and `rd_ready`. The engine checks that the device is ready, drives the strobe for a set number of cycles, and waits out a recovery gap before it accepts the next request.

Both device status lines pass through two-flop synchronisers before the state machine uses them. The machine has five states:

- IDLE accepts a request and moves to WAIT_READY.
- WAIT_READY moves to STROBE_ACTIVE once the synchronised status for the requested direction is low.
- STROBE_ACTIVE holds the strobe low for `WR_PULSE` or `RD_PULSE` cycles.
  - A write then moves to HOLD, which keeps the byte on the bus for one cycle with the strobe high.
  - A read captures the bus on the last low cycle and moves straight to RECOVER.
- RECOVER lasts `RECOV_GAP` cycles and then returns to IDLE, setting the completion flag.

Requests made while the engine is not in IDLE are dropped and recorded in a sticky overrun bit.

Top module: `pfifo_bridge`

## Requirements
- R1: After reset, `dev_wr_n` and `dev_rd_n` are 1, `dev_data_oe` is 0, and `busy`, `wr_done`, `rd_ready` and `overrun` are 0.
- R2: After a write is accepted, `dev_wr_n` does not go low until the synchronised `dev_txe_n` has been seen low. If `dev_txe_n` is already low and settled, the strobe goes low in the second cycle after the accepting edge.
- R3: `dev_wr_n` stays low for exactly `WR_PULSE` cycles. Throughout that time, `dev_data_oe` is 1 and `dev_data_o` equals the requested byte. Both stay valid for exactly one more cycle after the strobe rises.
- R4: After a read is accepted, `dev_rd_n` does not go low until the synchronised `dev_rxf_n` has been seen low. The two strobes are never low together.
- R5: `dev_rd_n` stays low for exactly `RD_PULSE` cycles, and `dev_data_oe` is 0 throughout. `rd_byte` takes the bus value from the last low cycle, and earlier bus values are discarded.
- R6: `busy` is 1 from the cycle after a request is accepted. After the strobe phase (including HOLD for a write), RECOVER keeps `busy` high for exactly `RECOV_GAP` cycles, and then `busy` falls.
- R7: `wr_done` is set when a write finishes, and is cleared by the edge that accepts the next write.
- R8: `rd_ready` is set when a read finishes, and is cleared by a `fetch` pulse.
- R9: A `wr_req` or `rd_req` while `busy` is 1 starts no transfer and sets `overrun`. A `status_rd` pulse clears `overrun`, but a new overrun in the same cycle wins.
- R10: When `wr_req` and `rd_req` arrive together in IDLE, the write is performed, the read is dropped, and `overrun` is set.
- R11: A status change on `dev_txe_n` or `dev_rxf_n` reaches the state machine through two flops. When the line falls at a negative clock edge, the strobe first shows low three rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Host pulse that starts a write |
| wr_byte | input | DATA_W | Byte to write, captured with `wr_req` |
| rd_req | input | 1 | Host pulse that starts a read |
| fetch | input | 1 | Host took `rd_byte`, so `rd_ready` clears |
| status_rd | input | 1 | Host read the status, so `overrun` clears |
| busy | output | 1 | A transfer is in progress |
| wr_done | output | 1 | The last write finished |
| rd_ready | output | 1 | A captured byte is waiting |
| overrun | output | 1 | Sticky flag for a dropped request |
| rd_byte | output | DATA_W | Byte captured by the last read |
| dev_rxf_n | input | 1 | Device has data to read, active low |
| dev_txe_n | input | 1 | Device can accept a byte, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_data_o | output | DATA_W | Byte driven towards the device |
| dev_data_oe | output | 1 | Output enable for `dev_data_o` |
| dev_data_i | input | DATA_W | Byte returned by the device |

## Verification
The assertions assume the host raises requests and `fetch` only as single-cycle pulses, and that `dev_data_i` is stable during the last low cycle of a read strobe. The stimulus drives every input at the falling clock edge and releases each request after one cycle. The device model changes its status lines only while no strobe is active and keeps them steady until the transfer completes. During a read, the model deliberately presents a wrong byte until the final strobe cycle. That departure is confined to cycles the engine must ignore.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_READY,
        S_STROBE_ACTIVE,
        S_HOLD,
        S_RECOVER
    } xfer_state_t;

    typedef enum logic {
        OP_WRITE,
        OP_READ
    } xfer_op_t;

endpackage

// File: rtl/pfifo_sync2.sv
module pfifo_sync2 #(
    parameter int WIDTH   = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= {WIDTH{RST_VAL}};
            dout   <= {WIDTH{RST_VAL}};
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/pfifo_timer.sv
module pfifo_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign expired = (count == '0);
endmodule

// File: rtl/pfifo_bridge.sv
module pfifo_bridge
    import pfifo_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int WR_PULSE  = 3,
    parameter int RD_PULSE  = 3,
    parameter int RECOV_GAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              rd_req,
    input  logic              fetch,
    input  logic              status_rd,
    output logic              busy,
    output logic              wr_done,
    output logic              rd_ready,
    output logic              overrun,
    output logic [DATA_W-1:0] rd_byte,
    input  logic              dev_rxf_n,
    input  logic              dev_txe_n,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic [DATA_W-1:0] dev_data_o,
    output logic              dev_data_oe,
    input  logic [DATA_W-1:0] dev_data_i
);
    localparam int MAX_AB = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
    localparam int MAX_C  = (MAX_AB > RECOV_GAP) ? MAX_AB : RECOV_GAP;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int RUN_W  = CNT_W + 1;

    xfer_state_t      state, state_nx;
    xfer_op_t         op;
    logic [DATA_W-1:0] out_byte;
    logic             rxf_sync, txe_sync;
    logic             dev_ready;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             accept;

    // Status inputs cross into the clock domain through two flops
    pfifo_sync2 #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({dev_rxf_n, dev_txe_n}),
        .dout ({rxf_sync, txe_sync})
    );

    pfifo_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    assign dev_ready = (op == OP_WRITE) ? !txe_sync : !rxf_sync;
    assign accept    = (state == S_IDLE) && (wr_req || rd_req);

    // Next-state and timer control
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: begin
                if (wr_req || rd_req)
                    state_nx = S_WAIT_READY;
            end
            S_WAIT_READY: begin
                if (dev_ready) begin
                    state_nx = S_STROBE_ACTIVE;
                    tmr_load = 1'b1;
                    tmr_val  = (op == OP_WRITE) ? CNT_W'(WR_PULSE - 1)
                                                : CNT_W'(RD_PULSE - 1);
                end
            end
            S_STROBE_ACTIVE: begin
                if (tmr_expired) begin
                    if (op == OP_WRITE) begin
                        state_nx = S_HOLD;
                    end else begin
                        state_nx = S_RECOVER;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RECOV_GAP - 1);
                    end
                end
            end
            S_HOLD: begin
                state_nx = S_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RECOV_GAP - 1);
            end
            S_RECOVER: begin
                if (tmr_expired)
                    state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // State register, request latch, capture and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op       <= OP_WRITE;
            out_byte <= '0;
            rd_byte  <= '0;
            wr_done  <= 1'b0;
            rd_ready <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op <= wr_req ? OP_WRITE : OP_READ;
                if (wr_req) begin
                    out_byte <= wr_byte;
                    wr_done  <= 1'b0;
                end
            end
            if (state == S_STROBE_ACTIVE && tmr_expired && op == OP_READ)
                rd_byte <= dev_data_i;
            if (fetch)
                rd_ready <= 1'b0;
            if (state == S_RECOVER && tmr_expired) begin
                if (op == OP_WRITE) wr_done  <= 1'b1;
                else                rd_ready <= 1'b1;
            end
            if (status_rd)
                overrun <= 1'b0;
            if ((state != S_IDLE && (wr_req || rd_req)) ||
                (state == S_IDLE && wr_req && rd_req))
                overrun <= 1'b1;
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        busy        = (state != S_IDLE);
        dev_wr_n    = !(state == S_STROBE_ACTIVE && op == OP_WRITE);
        dev_rd_n    = !(state == S_STROBE_ACTIVE && op == OP_READ);
        dev_data_oe = (op == OP_WRITE) &&
                      (state == S_STROBE_ACTIVE || state == S_HOLD);
        dev_data_o  = out_byte;
    end

    // Run length of the write strobe, for the width check
    logic [RUN_W-1:0] wr_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_low_run <= '0;
        else if (!dev_wr_n) begin
            if (wr_low_run != '1)
                wr_low_run <= wr_low_run + 1'b1;
        end else
            wr_low_run <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (dev_wr_n && dev_rd_n && !dev_data_oe && !busy)); // R1
    AST_WR_AFTER_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_wr_n) |-> !$past(txe_sync)); // R2
    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_wr_n) |-> (wr_low_run == RUN_W'(WR_PULSE))); // R3
    AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_wr_n) |-> (dev_data_oe && $stable(dev_data_o))); // R3
    AST_RD_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_rd_n) |-> !$past(rxf_sync)); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd_n || dev_wr_n)); // R4
    AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rd_n |-> !dev_data_oe); // R5
    AST_FETCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !busy) |=> !rd_ready); // R8
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_req || rd_req)) |=> overrun); // R9
endmodule

// File: tb/pfifo_bridge_test.sv
module pfifo_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int WR_P = 3;
    localparam int RD_P = 2;
    localparam int REC  = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_req = 0, rd_req = 0, fetch = 0, status_rd = 0;
    logic [7:0] wr_byte = '0;
    logic       busy, wr_done, rd_ready, overrun;
    logic [7:0] rd_byte;
    logic       dev_rxf_n = 1, dev_txe_n = 1;
    logic       dev_rd_n, dev_wr_n, dev_data_oe;
    logic [7:0] dev_data_o;
    logic [7:0] dev_data_i = '0;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfifo_bridge #(
        .DATA_W(8), .WR_PULSE(WR_P), .RD_PULSE(RD_P), .RECOV_GAP(REC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_byte(wr_byte),
        .rd_req(rd_req), .fetch(fetch), .status_rd(status_rd),
        .busy(busy), .wr_done(wr_done), .rd_ready(rd_ready),
        .overrun(overrun), .rd_byte(rd_byte), .dev_rxf_n(dev_rxf_n),
        .dev_txe_n(dev_txe_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
        .dev_data_o(dev_data_o), .dev_data_oe(dev_data_oe),
        .dev_data_i(dev_data_i)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run_txn(input bit is_wr, input logic [7:0] b, input int delay);
        int  idx = 0, low = 0, hold = 0, rec = 0, start_idx = -1, ready_idx = -1;
        int  other_low = 0;
        bit  seen = 0, data_bad = 0, early = 0;
        logic strobe;
        if (is_wr) dev_txe_n = (delay > 0);
        else       dev_rxf_n = (delay > 0);
        repeat (3) tick();
        if (is_wr) begin wr_byte = b; wr_req = 1; end
        else rd_req = 1;
        tick();
        wr_req = 0; rd_req = 0;
        chk("R6", "busy after accept", busy, 1);
        if (is_wr) chk("R7", "wr_done cleared by new write", wr_done, 0);
        while (busy && idx < 100) begin
            strobe = is_wr ? dev_wr_n : dev_rd_n;
            if (!(is_wr ? dev_rd_n : dev_wr_n)) other_low++;
            if (!strobe) begin
                if (!seen) start_idx = idx;
                seen = 1;
                low++;
                if (delay > 0 && ready_idx < 0) early = 1;
                if (is_wr && (!dev_data_oe || dev_data_o != b)) data_bad = 1;
                if (!is_wr) begin
                    if (dev_data_oe) data_bad = 1;
                    dev_data_i = (low == RD_P) ? b : ~b;
                end
            end else if (seen) begin
                if (is_wr && dev_data_oe && hold == 0 && rec == 0 && dev_data_o == b) hold++;
                else rec++;
            end
            if (delay > 0 && idx == delay) begin
                if (is_wr) dev_txe_n = 0; else dev_rxf_n = 0;
                ready_idx = idx;
            end
            tick();
            idx++;
        end
        if (is_wr) begin
            chk("R2", "strobe before space", early, 0);
            chk("R3", "write strobe width", low, WR_P);
            chk("R3", "write data valid", data_bad, 0);
            chk("R3", "hold cycles", hold, 1);
            chk("R7", "wr_done after write", wr_done, 1);
            if (delay == 0) chk("R2", "strobe start cycle", start_idx, 1);
        end else begin
            chk("R4", "strobe before data", early, 0);
            chk("R5", "read strobe width", low, RD_P);
            chk("R5", "bus not driven in read", data_bad, 0);
            chk("R5", "captured byte", rd_byte, b);
            chk("R8", "rd_ready after read", rd_ready, 1);
            chk("R5", "no hold in read", hold, 0);
        end
        chk("R4", "opposite strobe low", other_low, 0);
        if (delay > 0) chk("R11", "sync latency", start_idx - ready_idx, 3);
        chk("R6", "recovery cycles", rec, REC);
        dev_txe_n = 1; dev_rxf_n = 1; dev_data_i = '0;
        if (!is_wr) begin
            fetch = 1; tick(); fetch = 0;
            chk("R8", "rd_ready after fetch", rd_ready, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pulses, wr_low, rd_low, wrong;
        logic prev;
        rst_n = 0;
        repeat (3) tick();
        chk("R1", "wr_n in reset", dev_wr_n, 1);
        rst_n = 1;
        tick();
        chk("R1", "wr_n", dev_wr_n, 1);
        chk("R1", "rd_n", dev_rd_n, 1);
        chk("R1", "oe", dev_data_oe, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "wr_done", wr_done, 0);
        chk("R1", "rd_ready", rd_ready, 0);
        chk("R1", "overrun", overrun, 0);

        for (int w = 0; w < 256; w++)
            run_txn(1'b1, 8'(w), w % 4);
        for (int r = 0; r < 256; r++)
            run_txn(1'b0, 8'((r * 37 + 11) & 255), (r / 4) % 4);
        chk("R9", "no overrun from clean traffic", overrun, 0);

        // R9: request while busy is dropped
        dev_txe_n = 1; repeat (3) tick();
        wr_byte = 8'hA5; wr_req = 1; tick();
        wr_byte = 8'h3C; tick();
        wr_req = 0;
        chk("R9", "overrun set", overrun, 1);
        dev_txe_n = 0;
        pulses = 0; wrong = 0; prev = 1;
        for (int i = 0; i < 40; i++) begin
            if (prev && !dev_wr_n) pulses++;
            if (!dev_wr_n && dev_data_o != 8'hA5) wrong++;
            prev = dev_wr_n;
            tick();
        end
        chk("R9", "single write pulse", pulses, 1);
        chk("R9", "dropped byte never driven", wrong, 0);
        chk("R9", "idle after drop", busy, 0);
        status_rd = 1; tick(); status_rd = 0;
        chk("R9", "overrun cleared", overrun, 0);

        // R9: set wins over clear
        dev_txe_n = 1; repeat (3) tick();
        wr_req = 1; tick(); wr_req = 0;
        rd_req = 1; status_rd = 1; tick(); rd_req = 0; status_rd = 0;
        chk("R9", "set wins over clear", overrun, 1);
        dev_txe_n = 0;
        while (busy) tick();
        status_rd = 1; tick(); status_rd = 0;
        chk("R9", "overrun cleared again", overrun, 0);
        dev_txe_n = 1;

        // R10: simultaneous requests
        dev_txe_n = 0; dev_rxf_n = 0; repeat (3) tick();
        wr_byte = 8'h5A; wr_req = 1; rd_req = 1; tick();
        wr_req = 0; rd_req = 0;
        wr_low = 0; rd_low = 0;
        for (int i = 0; i < 30; i++) begin
            if (!dev_wr_n) wr_low++;
            if (!dev_rd_n) rd_low++;
            tick();
        end
        chk("R10", "write performed", wr_low, WR_P);
        chk("R10", "read dropped", rd_low, 0);
        chk("R10", "overrun set", overrun, 1);
        chk("R10", "wr_done", wr_done, 1);
        dev_txe_n = 1; dev_rxf_n = 1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule